// File: doc/BRIEF.md
# CORDIC Sine and Cosine Generator

This block turns a phase word into a sine and cosine pair. It is a fully pipelined rotation-mode CORDIC engine and accepts one new angle on every clock. The phase is a binary angle: the unsigned 16-bit word covers exactly one turn, so a phase accumulator can feed it directly and wrap-around is free. Results appear as 16-bit two's-complement words scaled to ±32767, with a valid strobe that follows the input strobe after a fixed delay.

Before the iterations start, the angle is folded into the half-plane between -90° and +90°. A half-turn fold negates both results at the end. The start vector is pre-scaled by the reciprocal of the CORDIC gain, so no multiplier is needed on the output to restore unity amplitude. A last stage removes the small angle residue that is left after the final micro-rotation. The same stage rounds to nearest with ties away from zero and clamps symmetrically, so the code -32768 never appears and the two half-cycles carry no bias relative to each other.

Top module: `cordic_sincos`

## Requirements
- R1: The phase input is unsigned binary angle. Code c stands for c·360/65536 degrees, so 0x4000 is 90°, 0x8000 is 180° and 0xC000 is 270°.
- R2: For every one of the 65536 codes, out_sin and out_cos are within ±1 of round(32767·sin θ) and round(32767·cos θ).
- R3: Both outputs stay inside -32767..+32767. The code 0x8000 (-32768) is never produced.
- R4: If in_valid is high in clock cycle n, out_valid is high in cycle n+18 and carries that angle's results. out_valid is in_valid delayed by exactly 18 cycles, and a new angle is taken every cycle.
- R5: A rising clock edge with rst_n low discards every angle in flight. out_valid is low from the next cycle until valid angles presented after reset reach the output.
- R6: Gain compensation gives full amplitude. Over a full turn each output reaches at least +32766 and at most -32766.
- R7: Half-turn antisymmetry is exact: for every code c below 0x8000, the results for c+0x8000 are the exact negatives of those for c.
- R8: Rounding is to nearest, not toward zero. Within each quadrant, the mean signed sine error against 32767·sin θ is smaller than 0.25 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks in_angle as an angle to convert this cycle |
| in_angle | input | 16 | Phase as an unsigned binary angle (one turn per full word) |
| out_valid | output | 1 | Marks out_sin and out_cos as results |
| out_sin | output | OUT_W (16) | Signed sine scaled to ±32767 |
| out_cos | output | OUT_W (16) | Signed cosine scaled to ±32767 |

## Verification
Some properties are checked by the assertions on every cycle. The folded angle must lie within a quarter turn of zero. The residual angle must shrink below each stage's own rotation step, which is the CORDIC convergence condition, and be tiny on entry to the final stage. A valid output may never carry the forbidden minimum code, and reset must clear the output strobe. Accuracy against an ideal sine, exact half-turn antisymmetry, the per-quadrant rounding bias, full-scale amplitude and the exact 18-cycle valid alignment under gapped strobes depend on many cycles and on real-valued references. Only the bench's full-turn sweep and its directed sequences can show those.

// File: rtl/cordic_sc_pkg.sv
// Package: shared constants of the CORDIC sine/cosine pipeline.
// Assumes a 16-bit binary-angle phase. The angle datapath carries ZF extra
// fraction bits, so one turn equals 2^(ANGLE_W+ZF) angle units.
package cordic_sc_pkg;

    localparam int ANGLE_W = 16;   // phase word width, one turn per full word
    localparam int ZF      = 8;    // fraction bits below one phase LSB
    localparam int MAX_ITER = 16;  // length of the rotation-step table

    // Rotation step of iteration i: arctan(2^-i) in units of 2^-24 turn, rounded.
    function automatic int atan_units(input int i);
        case (i)
            0:  return 2097152;
            1:  return 1238021;
            2:  return 654136;
            3:  return 332050;
            4:  return 166669;
            5:  return 83416;
            6:  return 41718;
            7:  return 20860;
            8:  return 10430;
            9:  return 5215;
            10: return 2608;
            11: return 1304;
            12: return 652;
            13: return 326;
            14: return 163;
            15: return 81;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/cordic_sc_fold.sv
// Module: quadrant fold stage.
// Maps the phase into the range -90..+90 degrees. Angles in the second and
// third quadrants are moved by half a turn, which only flips the top bit, and
// a negate flag travels down the pipe so the results are inverted at the end.
// Assumes ZW >= ANGLE_W + ZF + 1.
module cordic_sc_fold import cordic_sc_pkg::*; #(
    parameter int ZW = ANGLE_W + ZF + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid_i,
    input  logic [ANGLE_W-1:0]       angle_i,
    output logic                     valid_o,
    output logic                     neg_o,
    output logic signed [ZW-1:0]     z_o
);
    localparam int EXT_W = ZW - ANGLE_W - ZF;
    localparam int LIM   = 1 << (ANGLE_W - 2 + ZF);   // a quarter turn in angle units

    logic                   far_side;
    logic [ANGLE_W-1:0]     shifted;

    // Decide whether the angle lies beyond +-90 degrees and move it by half a turn.
    always_comb begin
        far_side = angle_i[ANGLE_W-1] ^ angle_i[ANGLE_W-2];
        shifted  = {angle_i[ANGLE_W-1] ^ far_side, angle_i[ANGLE_W-2:0]};
    end

    // Valid bit register, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // Register the signed, fraction-extended angle and the negate flag.
    always_ff @(posedge clk) begin
        z_o   <= {{EXT_W{shifted[ANGLE_W-1]}}, shifted, {ZF{1'b0}}};
        neg_o <= far_side;
    end

    // R1: the folded angle always lies within a quarter turn of zero.
    assert_fold_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (z_o >= -LIM && z_o < LIM))
        else $error("folded angle outside -90..+90 degrees");

endmodule

// File: rtl/cordic_sc_stage.sv
// Module: one CORDIC micro-rotation.
// Rotates (x, y) by +-arctan(2^-SHIFT), with the direction taken from the sign
// of the residual angle z, and steps z toward zero by the same table angle.
// Assumes |z_i| is at most twice this stage's step, which holds by convergence.
module cordic_sc_stage import cordic_sc_pkg::*; #(
    parameter int DW    = 23,
    parameter int ZW    = ANGLE_W + ZF + 2,
    parameter int SHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic                 neg_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    output logic                 valid_o,
    output logic                 neg_o,
    output logic signed [DW-1:0] x_o,
    output logic signed [DW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    localparam logic signed [ZW-1:0] STEP = ZW'(atan_units(SHIFT));
    localparam int BOUND = atan_units(SHIFT) + 16;

    logic                 ccw;
    logic signed [DW-1:0] x_sh;
    logic signed [DW-1:0] y_sh;

    // Pick the direction and form the arithmetically shifted cross terms.
    always_comb begin
        ccw  = !z_i[ZW-1];
        x_sh = x_i >>> SHIFT;
        y_sh = y_i >>> SHIFT;
    end

    // Valid bit register, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // Apply the micro-rotation and update the residual angle.
    always_ff @(posedge clk) begin
        neg_o <= neg_i;
        if (ccw) begin
            x_o <= x_i - y_sh;
            y_o <= y_i + x_sh;
            z_o <= z_i - STEP;
        end else begin
            x_o <= x_i + y_sh;
            y_o <= y_i - x_sh;
            z_o <= z_i + STEP;
        end
    end

    // R2: the residual never exceeds this stage's step (the convergence condition).
    assert_converge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (z_o <= BOUND && z_o >= -BOUND))
        else $error("residual angle not converging at shift %0d", SHIFT);

endmodule

// File: rtl/cordic_sc_finish.sv
// Module: residual trim, rounding, unfold and clamp.
// Removes the small residual angle left after the last micro-rotation with a
// first-order correction (sin += x*e, cos -= y*e). It then rounds away the
// GUARD bits to nearest with ties away from zero, negates the results for
// folded angles and clamps both outputs to +-(2^(OUT_W-1)-1).
// Assumes |z_i| < RES_BOUND, so the products fit easily in 64 bits.
module cordic_sc_finish #(
    parameter int OUT_W     = 16,
    parameter int GUARD     = 6,
    parameter int DW        = OUT_W + GUARD + 1,
    parameter int ZW        = 26,
    parameter int TRIM_SH   = 29,
    parameter int RES_BOUND = 113
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_i,
    input  logic                    neg_i,
    input  logic signed [DW-1:0]    x_i,
    input  logic signed [DW-1:0]    y_i,
    input  logic signed [ZW-1:0]    z_i,
    output logic                    valid_o,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o
);
    localparam logic signed [63:0] HALF    = 64'sd1 <<< (GUARD - 1);
    localparam logic signed [63:0] MAXV    = (64'sd1 <<< (OUT_W - 1)) - 64'sd1;
    localparam logic signed [63:0] TWO_PI5 = 64'sd201;   // 2*pi scaled by 2^5
    localparam logic signed [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [63:0] trim_s, trim_c, raw_s, raw_c, sin_c, cos_c;

    // Round to nearest, ties away from zero, so that +v and -v round as mirror images.
    function automatic logic signed [63:0] round_sym(input logic signed [63:0] v);
        if (v < 0) return -((-v + HALF) >>> GUARD);
        else       return (v + HALF) >>> GUARD;
    endfunction

    // Clamp to the symmetric output range.
    function automatic logic signed [63:0] clamp_sym(input logic signed [63:0] v);
        if (v > MAXV)  return MAXV;
        if (v < -MAXV) return -MAXV;
        return v;
    endfunction

    // Trim the residual, round, unfold and clamp.
    always_comb begin
        trim_s = (64'(x_i) * 64'(z_i) * TWO_PI5) >>> TRIM_SH;
        trim_c = (64'(y_i) * 64'(z_i) * TWO_PI5) >>> TRIM_SH;
        raw_s  = round_sym(64'(y_i) + trim_s);
        raw_c  = round_sym(64'(x_i) - trim_c);
        if (neg_i) begin
            raw_s = -raw_s;
            raw_c = -raw_c;
        end
        sin_c = clamp_sym(raw_s);
        cos_c = clamp_sym(raw_c);
    end

    // Valid bit register, cleared by the synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_o <= 1'b0;
        else        valid_o <= valid_i;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        sin_o <= OUT_W'(sin_c);
        cos_o <= OUT_W'(cos_c);
    end

    // R2: the residual after the last micro-rotation is small enough for a linear trim.
    assert_residual_small_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (z_i < RES_BOUND && z_i > -RES_BOUND))
        else $error("residual too large for the trim stage");

    // R3: a valid result never carries the most negative code.
    assert_no_min_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sin_o != MIN_CODE && cos_o != MIN_CODE))
        else $error("output reached the asymmetric minimum code");

endmodule

// File: rtl/cordic_sincos.sv
// Module: pipelined CORDIC sine/cosine generator (top).
// Chain: fold stage, ITER micro-rotation stages, finish stage. Latency is
// ITER+2 cycles and the throughput is one angle per clock. The start vector is
// (X0, 0), where X0 is the full-scale amplitude divided by the CORDIC gain, so
// the pipeline ends at unity amplitude. Assumes ITER <= MAX_ITER and GUARD >= 1.
module cordic_sincos import cordic_sc_pkg::*; #(
    parameter int OUT_W = 16,
    parameter int GUARD = 6,
    parameter int ITER  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [ANGLE_W-1:0]      in_angle,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_sin,
    output logic signed [OUT_W-1:0] out_cos
);
    localparam int  DW        = OUT_W + GUARD + 1;
    localparam int  ZW        = ANGLE_W + ZF + 2;
    localparam real GAIN      = 1.6467602581210654;
    localparam int  X0        = int'((2.0 ** (OUT_W - 1) - 1.0) * (2.0 ** GUARD) / GAIN);
    localparam int  TRIM_SH   = ANGLE_W + ZF + 5;
    localparam int  RES_BOUND = atan_units(ITER - 1) + 32;

    logic signed [DW-1:0] xa [0:ITER];
    logic signed [DW-1:0] ya [0:ITER];
    logic signed [ZW-1:0] za [0:ITER];
    logic                 na [0:ITER];
    logic                 va [0:ITER];

    // Gain-compensated start vector on the positive x axis.
    assign xa[0] = DW'(X0);
    assign ya[0] = '0;

    cordic_sc_fold #(.ZW(ZW)) u_fold (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (in_valid),
        .angle_i (in_angle),
        .valid_o (va[0]),
        .neg_o   (na[0]),
        .z_o     (za[0])
    );

    for (genvar g = 0; g < ITER; g++) begin : g_rot
        cordic_sc_stage #(.DW(DW), .ZW(ZW), .SHIFT(g)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (va[g]),
            .neg_i   (na[g]),
            .x_i     (xa[g]),
            .y_i     (ya[g]),
            .z_i     (za[g]),
            .valid_o (va[g+1]),
            .neg_o   (na[g+1]),
            .x_o     (xa[g+1]),
            .y_o     (ya[g+1]),
            .z_o     (za[g+1])
        );
    end

    cordic_sc_finish #(
        .OUT_W(OUT_W), .GUARD(GUARD), .DW(DW), .ZW(ZW),
        .TRIM_SH(TRIM_SH), .RES_BOUND(RES_BOUND)
    ) u_finish (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (va[ITER]),
        .neg_i   (na[ITER]),
        .x_i     (xa[ITER]),
        .y_i     (ya[ITER]),
        .z_i     (za[ITER]),
        .valid_o (out_valid),
        .sin_o   (out_sin),
        .cos_o   (out_cos)
    );

    // R5: a reset edge leaves no valid result behind it.
    assert_valid_cleared_R5: assert property (@(posedge clk)
        !rst_n |=> !out_valid)
        else $error("out_valid high after a reset edge");

endmodule

// File: tb/test_cordic_sincos.sv
// Bench for cordic_sincos: a table of directed vectors, a full-turn sweep
// against a real-valued model, gapped-strobe alignment, and reset checks.
module test_cordic_sincos;
    localparam int  LAT   = 18;
    localparam int  NCODE = 65536;
    localparam int  HALFT = 32768;
    localparam real TWO_PI = 6.283185307179586;

    // {angle, expected sin, expected cos}; exact values, checked to +-1 (R1, R2)
    localparam logic [47:0] VECS [0:7] = '{
        48'h0000_0000_7FFF, 48'h2000_5A82_5A82, 48'h4000_7FFF_0000, 48'h6000_5A82_A57E,
        48'h8000_0000_8001, 48'hA000_A57E_A57E, 48'hC000_8001_0000, 48'hE000_A57E_5A82
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_angle = '0;
    logic        out_valid;
    logic signed [15:0] out_sin, out_cos;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    shortint s_half [0:HALFT-1];
    shortint c_half [0:HALFT-1];
    real     qsum   [0:3];
    int      smax = -40000, smin = 40000, cmax = -40000, cmin = 40000;
    bit      hist   [0:79];

    always #5 clk = ~clk;

    cordic_sincos i_cordic_sincos (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_angle  (in_angle),
        .out_valid (out_valid),
        .out_sin   (out_sin),
        .out_cos   (out_cos)
    );

    task automatic check(input string req, input string what, input int act, input int exp, input int tol);
        n_tests++;
        if (act - exp > tol || exp - act > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int ideal(input int code, input bit want_sin);
        real a = TWO_PI * real'(code) / 65536.0;
        real v = 32767.0 * (want_sin ? $sin(a) : $cos(a));
        return $rtoi($floor(v + 0.5));
    endfunction

    task automatic judge_sweep(input int k);
        int  s = int'(out_sin);
        int  c = int'(out_cos);
        real es = 32767.0 * $sin(TWO_PI * real'(k) / 65536.0);
        check("R2", $sformatf("sin @%0h", k), s, ideal(k, 1'b1), 1);
        check("R2", $sformatf("cos @%0h", k), c, ideal(k, 1'b0), 1);
        check("R3", $sformatf("min code @%0h", k),
              (s < -32767 || c < -32767) ? 1 : 0, 0, 0);
        if (k < HALFT) begin
            s_half[k] = shortint'(s);
            c_half[k] = shortint'(c);
        end else begin
            check("R7", $sformatf("sin antisym @%0h", k), s, -int'(s_half[k-HALFT]), 0);
            check("R7", $sformatf("cos antisym @%0h", k), c, -int'(c_half[k-HALFT]), 0);
        end
        qsum[k >> 14] += real'(s) - es;
        if (s > smax) smax = s;
        if (s < smin) smin = s;
        if (c > cmax) cmax = c;
        if (c < cmin) cmin = c;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int q = 0; q < 4; q++) qsum[q] = 0.0;

        // R5: reset state
        repeat (3) @(negedge clk);
        check("R5", "out_valid during reset", int'(out_valid), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5", "out_valid after reset", int'(out_valid), 0, 0);

        // Table of directed vectors: R1 angle format, R2 values, R4 exact latency
        for (int v = 0; v < 8; v++) begin
            in_angle = VECS[v][47:32];
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            repeat (LAT - 2) @(negedge clk);
            check("R4", $sformatf("early valid vec %0d", v), int'(out_valid), 0, 0);
            @(negedge clk);
            check("R4", $sformatf("valid at 18 vec %0d", v), int'(out_valid), 1, 0);
            check("R1", $sformatf("sin vec %0d", v), int'(out_sin), int'($signed(VECS[v][31:16])), 1);
            check("R1", $sformatf("cos vec %0d", v), int'(out_cos), int'($signed(VECS[v][15:0])), 1);
            @(negedge clk);
            check("R4", $sformatf("single pulse vec %0d", v), int'(out_valid), 0, 0);
        end

        // Full-turn sweep, one angle per clock (R2, R3, R4, R6, R7, R8)
        fork
            begin
                for (int k = 0; k < NCODE; k++) begin
                    in_angle = 16'(k);
                    in_valid = 1'b1;
                    @(negedge clk);
                end
                in_valid = 1'b0;
            end
            begin
                int got = 0;
                int idle = 0;
                while (got < NCODE && idle < 100) begin
                    @(negedge clk);
                    if (out_valid) begin
                        judge_sweep(got);
                        got++;
                        idle = 0;
                    end else begin
                        idle++;
                    end
                end
                check("R4", "back-to-back results received", got, NCODE, 0);
            end
        join

        check("R6", "sin peak", smax >= 32766 ? 1 : 0, 1, 0);
        check("R6", "sin trough", smin <= -32766 ? 1 : 0, 1, 0);
        check("R6", "cos peak", cmax >= 32766 ? 1 : 0, 1, 0);
        check("R6", "cos trough", cmin <= -32766 ? 1 : 0, 1, 0);
        for (int q = 0; q < 4; q++) begin
            real m = qsum[q] / 16384.0;
            check("R8", $sformatf("mean sin error x1000 q%0d", q), $rtoi(m * 1000.0), 0, 249);
        end

        // R4: gapped strobe, out_valid must mirror in_valid 18 cycles later
        repeat (4) @(negedge clk);
        for (int i = 0; i < 80; i++) begin
            if (i >= LAT)
                check("R4", $sformatf("gapped valid cycle %0d", i), int'(out_valid), int'(hist[i-LAT]), 0);
            hist[i]  = (i < 60) && ((i % 3 == 0) || (i % 7 == 1));
            in_valid = hist[i];
            in_angle = 16'(i * 997);
            @(negedge clk);
        end

        // R5: reset in mid-stream discards every angle in flight
        for (int i = 0; i < 10; i++) begin
            in_valid = 1'b1;
            in_angle = 16'(i * 4001);
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n    = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            check("R5", $sformatf("flushed cycle %0d", i), int'(out_valid), 0, 0);
        end

        // R5: the pipe works again after the mid-stream reset
        in_angle = 16'h2000;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        check("R5", "valid after recovery", int'(out_valid), 1, 0);
        check("R5", "sin after recovery", int'(out_sin), 23170, 1);

        done = 1'b1;
        finish_run();
    end

endmodule